// File: doc/BRIEF.md
# System Bus Address Decoder

This block routes the byte reads and byte writes of a CPU across a 16-bit address space. It sorts each address into one of four windows: the cartridge ROM port, the work RAM port, the I/O page and a small high RAM. Inside the I/O page it decodes a second time. Two serial bytes, the interrupt-flag register and a sound range that is ignored live inside the block. The timer registers are passed out on a port. Any address outside these windows raises an error pulse, and a read of it returns 0xFF.

Each request is either a single byte or a 16-bit word. A word access becomes two byte accesses in two consecutive cycles: the low byte at the request address, then the high byte at the next address. The block is ready for a new request again when both bytes are done. External ports (ROM, work RAM, timer) are expected to return read data in the same cycle as their select. The response arrives one cycle after the final byte.

Top module: `membus_router`

## Requirements
- R1: Addresses 0x0000–0x7FFF drive `rom_sel` with `rom_addr` = address[14:0]. A read returns `rom_rdata`. A write is forwarded with `rom_we`=1 and `rom_wdata`.
- R2: Addresses 0xC000–0xDFFF drive `wram_sel` with `wram_addr` = address − 0xC000. A read returns `wram_rdata`. A write is forwarded with `wram_we`.
- R3: Addresses 0xFF80–0xFFFE reach an internal 128-byte high RAM at index address − 0xFF80. A read returns the byte last written there.
- R4: 0xFF01 (serial data) and 0xFF02 (serial control) are independent read/write bytes. Both are 0x00 after reset.
- R5: 0xFF04–0xFF07 drive `tmr_sel` with `tmr_reg` = address[1:0]. A read returns `tmr_rdata`. A write is forwarded with `tmr_we` and `tmr_wdata`.
- R6: 0xFF0F is the interrupt-flag register. Bits 4..0 are stored from a write. Bits 7..5 always read as 1, so it reads 0xE0 after reset.
- R7: A read in 0xFF10–0xFF3F returns 0x00 with no error. A write there raises no external select and changes no register.
- R8: Any other address is unmapped: 0x8000–0xBFFF, 0xE000–0xFEFF, 0xFFFF, and inside the I/O page 0xFF00, 0xFF03, 0xFF08–0xFF0E and 0xFF40–0xFF7F. An access to one of them raises `rsp_err` for exactly the one cycle of its `rsp_done`. A read of that byte returns 0xFF. A write there changes nothing.
- R9: A byte request is accepted when `req_valid` and `req_ready` are both high and `req_wide`=0. `rsp_done` is high in the next cycle with `rsp_rdata` = {0x00, byte}. A write responds with `rsp_rdata` = 0x0000.
- R10: A word request (`req_wide`=1) accesses the low byte at the address in the cycle it is accepted. In the next cycle, while `req_ready` is 0, it accesses the high byte at address+1, where 0xFFFF wraps to 0x0000. `rsp_done` then follows with `rsp_rdata` = {high, low}. For a write, the low byte is `req_wdata[7:0]` and the high byte is `req_wdata[15:8]`. `rsp_err` is set if either byte is unmapped.
- R11: During and after reset, `req_ready`=1, `rsp_done`=0 and `rsp_err`=0.
- R12: At most one of `rom_sel`, `wram_sel` and `tmr_sel` is high at a time. None is high while no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_wide | input | 1 | 1 = 16-bit access, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (low byte used for byte writes) |
| rsp_done | output | 1 | Access completed (one-cycle pulse) |
| rsp_err | output | 1 | Completed access touched an unmapped address |
| rsp_rdata | output | 16 | Read result, zero for writes |
| rom_sel | output | 1 | Cartridge ROM port select |
| rom_we | output | 1 | Cartridge ROM port write |
| rom_addr | output | 15 | Cartridge ROM port address |
| rom_wdata | output | 8 | Cartridge ROM port write byte |
| rom_rdata | input | 8 | Cartridge ROM port read byte |
| wram_sel | output | 1 | Work RAM select |
| wram_we | output | 1 | Work RAM write |
| wram_addr | output | 13 | Work RAM index |
| wram_wdata | output | 8 | Work RAM write byte |
| wram_rdata | input | 8 | Work RAM read byte |
| tmr_sel | output | 1 | Timer register select |
| tmr_we | output | 1 | Timer register write |
| tmr_reg | output | 2 | Timer register index |
| tmr_wdata | output | 8 | Timer write byte |
| tmr_rdata | input | 8 | Timer read byte |

## Verification
A wrong region or I/O decode shows at once, in the same cycle as the request, as a missing or wrong select, or as a misrouted address on the external ports. The stored bytes (serial, interrupt flag, high RAM) only show a corruption on a later read, one cycle after that read is accepted. A broken word sequencer shows as `req_ready` staying low for a wrong number of cycles, as a missing `rsp_done`, or as swapped halves in `rsp_rdata` two cycles after acceptance. An error flag that is stuck or lost shows on the `rsp_done` cycle of the offending access.

// File: rtl/membus_pkg.sv
`timescale 1ns/1ps
package membus_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int ADDR_W    = 16;
    localparam int ROM_AW    = 15;
    localparam int WRAM_AW   = 13;
    localparam int TMR_IDX_W = 2;

    // top-level windows
    localparam logic [ADDR_W-1:0] ROM_END    = 16'h7FFF;
    localparam logic [ADDR_W-1:0] WRAM_FIRST = 16'hC000;
    localparam logic [ADDR_W-1:0] WRAM_LAST  = 16'hDFFF;
    localparam logic [ADDR_W-1:0] IOPG_FIRST = 16'hFF00;
    localparam logic [ADDR_W-1:0] IOPG_LAST  = 16'hFF7F;
    localparam logic [ADDR_W-1:0] HRAM_FIRST = 16'hFF80;
    localparam logic [ADDR_W-1:0] HRAM_LAST  = 16'hFFFE;

    // offsets inside the I/O page
    localparam logic [BYTE_W-1:0] OFF_SER_DATA  = 8'h01;
    localparam logic [BYTE_W-1:0] OFF_SER_CTRL  = 8'h02;
    localparam logic [BYTE_W-1:0] OFF_TMR_FIRST = 8'h04;
    localparam logic [BYTE_W-1:0] OFF_TMR_LAST  = 8'h07;
    localparam logic [BYTE_W-1:0] OFF_IFLAG     = 8'h0F;
    localparam logic [BYTE_W-1:0] OFF_SND_FIRST = 8'h10;
    localparam logic [BYTE_W-1:0] OFF_SND_LAST  = 8'h3F;

    typedef enum logic [2:0] {
        MAP_ROM,
        MAP_WRAM,
        MAP_IOPG,
        MAP_HRAM,
        MAP_HOLE
    } map_region_e;

    typedef enum logic [2:0] {
        IO_SDATA,
        IO_SCTRL,
        IO_TIMER,
        IO_IFLAG,
        IO_SOUND,
        IO_MISS
    } io_slot_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } byte_acc_t;

    function automatic map_region_e region_of(input logic [ADDR_W-1:0] a);
        map_region_e r;
        if (a <= ROM_END)                           r = MAP_ROM;
        else if (a >= WRAM_FIRST && a <= WRAM_LAST) r = MAP_WRAM;
        else if (a >= IOPG_FIRST && a <= IOPG_LAST) r = MAP_IOPG;
        else if (a >= HRAM_FIRST && a <= HRAM_LAST) r = MAP_HRAM;
        else                                        r = MAP_HOLE;
        return r;
    endfunction

    function automatic io_slot_e io_slot_of(input logic [BYTE_W-1:0] off);
        io_slot_e s;
        if (off == OFF_SER_DATA)                              s = IO_SDATA;
        else if (off == OFF_SER_CTRL)                         s = IO_SCTRL;
        else if (off >= OFF_TMR_FIRST && off <= OFF_TMR_LAST) s = IO_TIMER;
        else if (off == OFF_IFLAG)                            s = IO_IFLAG;
        else if (off >= OFF_SND_FIRST && off <= OFF_SND_LAST) s = IO_SOUND;
        else                                                  s = IO_MISS;
        return s;
    endfunction

endpackage

// File: rtl/membus_region_dec.sv
`timescale 1ns/1ps
module membus_region_dec
    import membus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output map_region_e       region
);
    // first decode level: which window of the address space
    always_comb begin
        region = region_of(addr);
    end
endmodule

// File: rtl/membus_io_block.sv
`timescale 1ns/1ps
module membus_io_block
    import membus_pkg::*;
#(
    parameter int                IF_BITS   = 5,
    parameter logic [BYTE_W-1:0] FILL_BYTE = 8'hFF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic                 in_page,
    input  logic [BYTE_W-1:0]    off,
    input  logic [BYTE_W-1:0]    wdata,
    input  logic [BYTE_W-1:0]    tmr_rdata,
    output logic                 tmr_sel,
    output logic                 tmr_we,
    output logic [TMR_IDX_W-1:0] tmr_reg,
    output logic [BYTE_W-1:0]    tmr_wdata,
    output logic [BYTE_W-1:0]    rdata,
    output logic                 miss
);
    localparam int IF_PAD = BYTE_W - IF_BITS;

    io_slot_e           slot;
    logic               wr_hit;
    logic [BYTE_W-1:0]  ser_data_q;
    logic [BYTE_W-1:0]  ser_ctrl_q;
    logic [IF_BITS-1:0] iflag_q;

    // second decode level: slot inside the I/O page
    always_comb begin
        slot = io_slot_of(off);
    end

    assign wr_hit = acc_valid && acc_write && in_page;

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_data_q <= '0;
            ser_ctrl_q <= '0;
            iflag_q    <= '0;
        end else if (wr_hit) begin
            case (slot)
                IO_SDATA: ser_data_q <= wdata;
                IO_SCTRL: ser_ctrl_q <= wdata;
                IO_IFLAG: iflag_q    <= wdata[IF_BITS-1:0];
                default:  ;
            endcase
        end
    end

    assign tmr_sel   = acc_valid && in_page && (slot == IO_TIMER);
    assign tmr_we    = tmr_sel && acc_write;
    assign tmr_reg   = off[TMR_IDX_W-1:0];
    assign tmr_wdata = wdata;

    always_comb begin
        case (slot)
            IO_SDATA: rdata = ser_data_q;
            IO_SCTRL: rdata = ser_ctrl_q;
            IO_TIMER: rdata = tmr_rdata;
            IO_IFLAG: rdata = {{IF_PAD{1'b1}}, iflag_q};
            IO_SOUND: rdata = '0;
            default:  rdata = FILL_BYTE;
        endcase
    end

    assign miss = in_page && (slot == IO_MISS);
endmodule

// File: rtl/membus_hram.sv
`timescale 1ns/1ps
module membus_hram
    import membus_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/membus_router.sv
`timescale 1ns/1ps
module membus_router
    import membus_pkg::*;
#(
    parameter int                HRAM_DEPTH = 128,
    parameter int                IF_BITS    = 5,
    parameter logic [BYTE_W-1:0] FILL_BYTE  = 8'hFF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_wide,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    output logic                 rsp_done,
    output logic                 rsp_err,
    output logic [WORD_W-1:0]    rsp_rdata,
    output logic                 rom_sel,
    output logic                 rom_we,
    output logic [ROM_AW-1:0]    rom_addr,
    output logic [BYTE_W-1:0]    rom_wdata,
    input  logic [BYTE_W-1:0]    rom_rdata,
    output logic                 wram_sel,
    output logic                 wram_we,
    output logic [WRAM_AW-1:0]   wram_addr,
    output logic [BYTE_W-1:0]    wram_wdata,
    input  logic [BYTE_W-1:0]    wram_rdata,
    output logic                 tmr_sel,
    output logic                 tmr_we,
    output logic [TMR_IDX_W-1:0] tmr_reg,
    output logic [BYTE_W-1:0]    tmr_wdata,
    input  logic [BYTE_W-1:0]    tmr_rdata
);
    localparam int HRAM_AW = $clog2(HRAM_DEPTH);

    // word sequencer state
    logic              phase_hi;
    logic [ADDR_W-1:0] hold_addr;
    logic              hold_write;
    logic [BYTE_W-1:0] hold_wdata;
    logic [BYTE_W-1:0] lo_byte;
    logic              err_acc;

    byte_acc_t         cur;
    map_region_e       region;
    logic [BYTE_W-1:0] io_rdata;
    logic              io_miss;
    logic [BYTE_W-1:0] hram_rdata;
    logic              hram_wr;
    logic [BYTE_W-1:0] rbyte;
    logic [BYTE_W-1:0] rbyte_eff;
    logic              byte_miss;

    // the byte access carried out this cycle
    always_comb begin
        if (phase_hi) begin
            cur.valid = 1'b1;
            cur.write = hold_write;
            cur.addr  = hold_addr;
            cur.wdata = hold_wdata;
        end else begin
            cur.valid = req_valid;
            cur.write = req_write;
            cur.addr  = req_addr;
            cur.wdata = req_wdata[BYTE_W-1:0];
        end
    end

    assign req_ready = !phase_hi;

    membus_region_dec u_region (
        .addr   (cur.addr),
        .region (region)
    );

    membus_io_block #(
        .IF_BITS   (IF_BITS),
        .FILL_BYTE (FILL_BYTE)
    ) u_io (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (cur.valid),
        .acc_write (cur.write),
        .in_page   (region == MAP_IOPG),
        .off       (cur.addr[BYTE_W-1:0]),
        .wdata     (cur.wdata),
        .tmr_rdata (tmr_rdata),
        .tmr_sel   (tmr_sel),
        .tmr_we    (tmr_we),
        .tmr_reg   (tmr_reg),
        .tmr_wdata (tmr_wdata),
        .rdata     (io_rdata),
        .miss      (io_miss)
    );

    assign hram_wr = cur.valid && cur.write && (region == MAP_HRAM);

    membus_hram #(
        .DEPTH (HRAM_DEPTH)
    ) u_hram (
        .clk   (clk),
        .wr_en (hram_wr),
        .idx   (cur.addr[HRAM_AW-1:0]),
        .wdata (cur.wdata),
        .rdata (hram_rdata)
    );

    // external windows
    assign rom_sel    = cur.valid && (region == MAP_ROM);
    assign rom_we     = rom_sel && cur.write;
    assign rom_addr   = cur.addr[ROM_AW-1:0];
    assign rom_wdata  = cur.wdata;

    assign wram_sel   = cur.valid && (region == MAP_WRAM);
    assign wram_we    = wram_sel && cur.write;
    assign wram_addr  = cur.addr[WRAM_AW-1:0];
    assign wram_wdata = cur.wdata;

    // read byte selection
    always_comb begin
        case (region)
            MAP_ROM:  rbyte = rom_rdata;
            MAP_WRAM: rbyte = wram_rdata;
            MAP_IOPG: rbyte = io_rdata;
            MAP_HRAM: rbyte = hram_rdata;
            default:  rbyte = FILL_BYTE;
        endcase
    end

    assign rbyte_eff = cur.write ? '0 : rbyte;
    assign byte_miss = (region == MAP_HOLE) || ((region == MAP_IOPG) && io_miss);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_hi   <= 1'b0;
            hold_addr  <= '0;
            hold_write <= 1'b0;
            hold_wdata <= '0;
            lo_byte    <= '0;
            err_acc    <= 1'b0;
            rsp_done   <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            if (phase_hi) begin
                phase_hi  <= 1'b0;
                rsp_done  <= 1'b1;
                rsp_err   <= err_acc || byte_miss;
                rsp_rdata <= {rbyte_eff, lo_byte};
            end else if (req_valid) begin
                if (req_wide) begin
                    phase_hi   <= 1'b1;
                    hold_addr  <= req_addr + ADDR_W'(1);
                    hold_write <= req_write;
                    hold_wdata <= req_wdata[WORD_W-1:BYTE_W];
                    lo_byte    <= rbyte_eff;
                    err_acc    <= byte_miss;
                end else begin
                    rsp_done  <= 1'b1;
                    rsp_err   <= byte_miss;
                    rsp_rdata <= {{BYTE_W{1'b0}}, rbyte_eff};
                end
            end
        end
    end
endmodule

// File: rtl/membus_router_chk.sv
`timescale 1ns/1ps
module membus_router_chk
    import membus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_wide,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [WORD_W-1:0] rsp_rdata,
    input logic              rom_sel,
    input logic              wram_sel,
    input logic              tmr_sel
);
    assert_rom_route_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_addr[15]) |-> rom_sel);

    assert_timer_route_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_addr[15:2] == 14'h3FC1) |-> tmr_sel);

    assert_sound_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_wide && !req_write &&
         req_addr >= 16'hFF10 && req_addr <= 16'hFF3F)
        |=> (rsp_rdata == 16'h0000 && !rsp_err));

    assert_err_only_done_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_done);

    assert_byte_done_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_wide) |=> rsp_done);

    assert_wide_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_wide) |=> (!req_ready && !rsp_done));

    assert_wide_finish_R10: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> (req_ready && rsp_done));

    assert_sel_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_sel, wram_sel, tmr_sel}));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_valid) |-> !(rom_sel || wram_sel || tmr_sel));
endmodule

bind membus_router membus_router_chk chk_i (.*);

// File: tb/membus_router_tb_top.sv
`timescale 1ns/1ps
module membus_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_wide = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        rom_sel, rom_we;
    logic [14:0] rom_addr;
    logic [7:0]  rom_wdata, rom_rdata;
    logic        wram_sel, wram_we;
    logic [12:0] wram_addr;
    logic [7:0]  wram_wdata, wram_rdata;
    logic        tmr_sel, tmr_we;
    logic [1:0]  tmr_reg;
    logic [7:0]  tmr_wdata, tmr_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    membus_router dut_i (.*);

    // external models
    logic [7:0] wram_m [256];
    logic [7:0] tmr_m  [4];
    initial begin
        for (int i = 0; i < 256; i++) wram_m[i] = 8'h00;
        for (int i = 0; i < 4; i++)   tmr_m[i]  = 8'h00;
    end
    assign rom_rdata  = rom_addr[7:0] ^ {1'b0, rom_addr[14:8]};
    assign wram_rdata = wram_m[wram_addr[7:0]];
    assign tmr_rdata  = tmr_m[tmr_reg];
    always @(posedge clk) begin
        if (wram_sel && wram_we) wram_m[wram_addr[7:0]] <= wram_wdata;
        if (tmr_sel && tmr_we)   tmr_m[tmr_reg] <= tmr_wdata;
    end

    // scoreboard
    logic [15:0] exp_rd_q [$];
    logic        exp_err_q [$];
    string       exp_tag_q [$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_done) begin
                if (exp_rd_q.size() == 0) begin
                    n_checks++; n_fails++;
                    $display("FAIL R9: unexpected response actual %h expected none", rsp_rdata);
                end else begin
                    automatic logic [15:0] erd = exp_rd_q.pop_front();
                    automatic logic        eer = exp_err_q.pop_front();
                    automatic string       etg = exp_tag_q.pop_front();
                    check({etg, " rdata"}, {16'h0, rsp_rdata}, {16'h0, erd});
                    check({etg, " err"}, {31'h0, rsp_err}, {31'h0, eer});
                end
            end else if (rsp_err) begin
                n_checks++; n_fails++;
                $display("FAIL R8: error without done actual 1 expected 0");
            end
        end
    end

    // snapshots of the external ports: [0] first byte, [1] second byte
    logic [2:0]  s_sel   [2];
    logic        s_we    [2];
    logic [14:0] s_rom_a [2];
    logic [12:0] s_wram_a[2];
    logic [1:0]  s_tmr_r [2];
    logic [7:0]  s_wd    [2];
    logic        s_ready1;

    task automatic snap(input int k);
        s_sel[k]    = {rom_sel, wram_sel, tmr_sel};
        s_we[k]     = rom_we | wram_we | tmr_we;
        s_rom_a[k]  = rom_addr;
        s_wram_a[k] = wram_addr;
        s_tmr_r[k]  = tmr_reg;
        s_wd[k]     = rom_sel ? rom_wdata : (wram_sel ? wram_wdata : tmr_wdata);
    endtask

    task automatic acc(input logic wide, input logic wr, input logic [15:0] a,
                       input logic [15:0] wd, input logic [15:0] erd,
                       input logic eerr, input string tag);
        @(negedge clk);
        exp_rd_q.push_back(erd);
        exp_err_q.push_back(eerr);
        exp_tag_q.push_back(tag);
        req_valid = 1'b1; req_wide = wide; req_write = wr;
        req_addr = a; req_wdata = wd;
        #1 snap(0);
        @(negedge clk);
        req_valid = 1'b0; req_wide = 1'b0; req_write = 1'b0;
        if (wide) begin
            #1;
            s_ready1 = req_ready;
            snap(1);
        end
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        acc(1'b0, 1'b0, a, 16'h0, {8'h00, e}, 1'b0, tag);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        acc(1'b0, 1'b1, a, {8'h00, d}, 16'h0000, 1'b0, tag);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 ready", {31'h0, req_ready}, 32'h1);
        check("R11 done", {31'h0, rsp_done}, 32'h0);
        check("R11 err", {31'h0, rsp_err}, 32'h0);
        rst = 1'b0;

        rd(16'hFF0F, 8'hE0, "R6 R11 iflag reset");
        rd(16'hFF01, 8'h00, "R4 R11 serial data reset");
        rd(16'hFF02, 8'h00, "R4 R11 serial ctrl reset");

        // R1 ROM window
        rd(16'h1234, 8'h26, "R1 rom read");
        check("R1 rom addr", {17'h0, s_rom_a[0]}, 32'h1234);
        rd(16'h7FFF, 8'h80, "R1 rom top");
        wr(16'h2000, 8'h05, "R1 rom write");
        check("R1 R12 rom write sel", {29'h0, s_sel[0]}, 32'h4);
        check("R1 rom write we", {31'h0, s_we[0]}, 32'h1);
        check("R1 rom write addr", {17'h0, s_rom_a[0]}, 32'h2000);
        check("R1 rom write data", {24'h0, s_wd[0]}, 32'h05);

        // R2 work RAM
        wr(16'hD123, 8'hA5, "R2 wram write");
        check("R2 R12 wram sel", {29'h0, s_sel[0]}, 32'h2);
        check("R2 wram index", {19'h0, s_wram_a[0]}, 32'h1123);
        rd(16'hD123, 8'hA5, "R2 wram read");
        wr(16'hC000, 8'h3C, "R2 wram bottom write");
        rd(16'hC000, 8'h3C, "R2 wram bottom read");
        wr(16'hDFFF, 8'h7E, "R2 wram top write");
        check("R2 wram top index", {19'h0, s_wram_a[0]}, 32'h1FFF);
        rd(16'hDFFF, 8'h7E, "R2 wram top read");

        // R3 high RAM
        wr(16'hFF80, 8'h11, "R3 hram write low");
        check("R3 R12 hram no port", {29'h0, s_sel[0]}, 32'h0);
        wr(16'hFFFE, 8'h22, "R3 hram write high");
        rd(16'hFF80, 8'h11, "R3 hram read low");
        rd(16'hFFFE, 8'h22, "R3 hram read high");

        // R4 serial bytes
        wr(16'hFF01, 8'h55, "R4 serial data write");
        wr(16'hFF02, 8'h81, "R4 serial ctrl write");
        rd(16'hFF01, 8'h55, "R4 serial data read");
        rd(16'hFF02, 8'h81, "R4 serial ctrl read");

        // R5 timer forwarding
        wr(16'hFF05, 8'h77, "R5 timer write");
        check("R5 R12 timer sel", {29'h0, s_sel[0]}, 32'h1);
        check("R5 timer reg", {30'h0, s_tmr_r[0]}, 32'h1);
        check("R5 timer data", {24'h0, s_wd[0]}, 32'h77);
        rd(16'hFF05, 8'h77, "R5 timer read");
        wr(16'hFF07, 8'h05, "R5 timer ctrl write");
        rd(16'hFF07, 8'h05, "R5 timer ctrl read");
        rd(16'hFF04, 8'h00, "R5 timer div read");

        // R6 interrupt flag
        wr(16'hFF0F, 8'hFF, "R6 iflag write ff");
        rd(16'hFF0F, 8'hFF, "R6 iflag read ff");
        wr(16'hFF0F, 8'h00, "R6 iflag write 00");
        rd(16'hFF0F, 8'hE0, "R6 iflag read e0");
        wr(16'hFF0F, 8'h15, "R6 iflag write 15");
        rd(16'hFF0F, 8'hF5, "R6 iflag read f5");

        // R7 sound window
        wr(16'hFF20, 8'h99, "R7 sound write");
        check("R7 sound write no sel", {29'h0, s_sel[0]}, 32'h0);
        rd(16'hFF20, 8'h00, "R7 sound read");
        rd(16'hFF10, 8'h00, "R7 sound first");
        rd(16'hFF3F, 8'h00, "R7 sound last");
        rd(16'hFF01, 8'h55, "R7 serial untouched");
        rd(16'hFF0F, 8'hF5, "R7 iflag untouched");

        // R8 unmapped
        acc(1'b0, 1'b0, 16'h8000, 16'h0, 16'h00FF, 1'b1, "R8 hole 8000");
        check("R8 hole no sel", {29'h0, s_sel[0]}, 32'h0);
        acc(1'b0, 1'b0, 16'h9FFF, 16'h0, 16'h00FF, 1'b1, "R8 hole 9fff");
        acc(1'b0, 1'b0, 16'hA000, 16'h0, 16'h00FF, 1'b1, "R8 hole a000");
        acc(1'b0, 1'b0, 16'hE000, 16'h0, 16'h00FF, 1'b1, "R8 hole e000");
        acc(1'b0, 1'b0, 16'hFEFF, 16'h0, 16'h00FF, 1'b1, "R8 hole feff");
        acc(1'b0, 1'b0, 16'hFF00, 16'h0, 16'h00FF, 1'b1, "R8 hole ff00");
        acc(1'b0, 1'b0, 16'hFF03, 16'h0, 16'h00FF, 1'b1, "R8 hole ff03");
        acc(1'b0, 1'b0, 16'hFF08, 16'h0, 16'h00FF, 1'b1, "R8 hole ff08");
        acc(1'b0, 1'b0, 16'hFF0E, 16'h0, 16'h00FF, 1'b1, "R8 hole ff0e");
        acc(1'b0, 1'b0, 16'hFF40, 16'h0, 16'h00FF, 1'b1, "R8 hole ff40");
        acc(1'b0, 1'b0, 16'hFF7F, 16'h0, 16'h00FF, 1'b1, "R8 hole ff7f");
        acc(1'b0, 1'b0, 16'hFFFF, 16'h0, 16'h00FF, 1'b1, "R8 hole ffff");
        acc(1'b0, 1'b1, 16'hFF03, 16'h0012, 16'h0000, 1'b1, "R8 hole write ff03");
        check("R8 hole write no sel", {29'h0, s_sel[0]}, 32'h0);
        rd(16'hFF01, 8'h55, "R8 serial data unchanged");
        rd(16'hFF02, 8'h81, "R8 serial ctrl unchanged");
        acc(1'b0, 1'b1, 16'hE000, 16'h0033, 16'h0000, 1'b1, "R8 hole write e000");
        rd(16'hC000, 8'h3C, "R8 wram unchanged");

        // R10 word accesses
        acc(1'b1, 1'b1, 16'hFF90, 16'hBEEF, 16'h0000, 1'b0, "R10 wide hram write");
        check("R10 ready low in second byte", {31'h0, s_ready1}, 32'h0);
        rd(16'hFF90, 8'hEF, "R10 low byte at address");
        rd(16'hFF91, 8'hBE, "R10 high byte at address+1");
        acc(1'b1, 1'b0, 16'hFF90, 16'h0, 16'hBEEF, 1'b0, "R10 wide hram read");
        acc(1'b1, 1'b1, 16'hC010, 16'h1234, 16'h0000, 1'b0, "R10 wide wram write");
        check("R10 first wram index", {19'h0, s_wram_a[0]}, 32'h0010);
        check("R10 first wram data", {24'h0, s_wd[0]}, 32'h34);
        check("R10 second wram index", {19'h0, s_wram_a[1]}, 32'h0011);
        check("R10 second wram data", {24'h0, s_wd[1]}, 32'h12);
        acc(1'b1, 1'b0, 16'hC010, 16'h0, 16'h1234, 1'b0, "R10 wide wram read");
        acc(1'b1, 1'b0, 16'h1234, 16'h0, 16'h2726, 1'b0, "R10 wide rom read");
        acc(1'b1, 1'b0, 16'hFF01, 16'h0, 16'h8155, 1'b0, "R10 wide serial read");
        acc(1'b1, 1'b0, 16'hFFFE, 16'h0, 16'hFF22, 1'b1, "R10 wide high half unmapped");
        acc(1'b1, 1'b0, 16'hFFFF, 16'h0, 16'h00FF, 1'b1, "R10 wide wrap");
        check("R10 wrap rom sel", {29'h0, s_sel[1]}, 32'h4);
        check("R10 wrap rom addr", {17'h0, s_rom_a[1]}, 32'h0000);

        // R12 idle
        repeat (3) @(negedge clk);
        check("R12 idle selects", {29'h0, rom_sel, wram_sel, tmr_sel}, 32'h0);
        check("R9 all responses seen", exp_rd_q.size(), 32'h0);

        summary();
        $finish;
    end
endmodule